// File: doc/BRIEF.md
# Transceiver Register Access SPI Master

This block lets host logic read or write one byte of a radio transceiver's register file over a four-wire serial link. The transceiver exposes two register spaces. The short space uses 6-bit addresses and the long space uses 10-bit addresses. A single request names the space, the direction, the address and, for writes, the data byte. The block builds the command header for the chosen space and shifts the whole frame out under one chip-select low period. For reads it clocks the returned byte in. When the frame is finished it pulses `done`.

While a frame runs, the block forces the interrupt enable it passes to the host interrupt controller low. When the frame ends, that enable follows the host's own setting again. The serial clock runs at a fixed ratio of the system clock, set by `SCK_HALF` (system cycles per half SCK period). The default of 10 gives 10 MHz from a 200 MHz system clock.

Top module: `spi_reg_master`

## Requirements
- R1: A short write (`req_long`=0, `req_write`=1) sends 16 bits, MSB first: the byte `{0, addr[5:0], 1}`, then the data byte.
- R2: A short read sends the byte `{0, addr[5:0], 0}` and then clocks 8 more bits. `rd_data` then holds the 8 bits sampled from `miso` in those clocks, first bit in bit 7.
- R3: A long write sends 24 bits: `{1, addr[9:3]}`, then `{addr[2:0], 1, 0000}`, then the data byte.
- R4: A long read sends `{1, addr[9:3]}` and then `{addr[2:0], 00000}`, and clocks 8 more bits into `rd_data` as in R2.
- R5: The serial link uses SPI mode 0. `sck` idles low. `mosi` changes only while `sck` is low. `miso` is sampled at each rising `sck` edge.
- R6: `cs_n` goes low once per transaction, before the first rising `sck` edge, and stays low until after the last falling edge. `sck` is low whenever `cs_n` is high.
- R7: `irq_en_out` is 0 while `busy` is high and equals `irq_en_in` while `busy` is low.
- R8: A request (`req_valid`=1) is taken only when `busy` is low. `busy` rises in the cycle after it is taken and stays high until `done`. `done` is a one-cycle pulse with `busy` low. Requests made while busy start no frame.
- R9: Between two transactions, `cs_n` stays high for at least 2*`SCK_HALF` system cycles.
- R10: `rd_data` changes only at the end of a read. A write leaves it unchanged.
- R11: Within a frame, consecutive rising `sck` edges are 2*`SCK_HALF` system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a transaction (taken only when idle) |
| req_long | input | 1 | 1 = long address space, 0 = short |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Register address (bits 5:0 used in the short space) |
| req_wdata | input | 8 | Byte to write |
| irq_en_in | input | 1 | Host's interrupt enable setting |
| irq_en_out | output | 1 | Interrupt enable as seen by the interrupt controller |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Byte returned by the last read |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the transceiver |
| miso | input | 1 | Serial data from the transceiver |

## Verification
The bound checker watches the link rules on every cycle: the interrupt-enable gating while busy, that `sck` stays low outside chip select, that `mosi` changes only in the low phase, and the shape of `done` and `busy`. Whether each header carries the right address split and direction bit, whether the right byte comes back, whether writes leave `rd_data` alone, and the exact clock period and chip-select gap can only be seen through the bench's transceiver model. That model checks them over every short address and a spread of long addresses in both directions.

// File: rtl/spi_reg_master.sv
module spi_reg_master #(
  parameter int SCK_HALF = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_long,
  input  logic       req_write,
  input  logic [9:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic       irq_en_in,
  output logic       irq_en_out,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       sck,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int FW = 24;

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] div;
  logic [FW-1:0] sh, frame;
  logic [4:0]    bit_no, last_bit;
  logic [7:0]    rx;
  logic          rd_q, gap2, sck_q;
  logic          tick;

  assign tick       = (div == CW'(SCK_HALF - 1));
  assign busy       = (st != S_IDLE);
  assign cs_n       = (st == S_IDLE) || (st == S_GAP);
  assign sck        = sck_q;
  assign mosi       = sh[FW-1];
  assign irq_en_out = irq_en_in & ~busy;

  always_comb begin
    case ({req_long, req_write})
      2'b00:   frame = {1'b0, req_addr[5:0], 1'b0, 16'h0000};
      2'b01:   frame = {1'b0, req_addr[5:0], 1'b1, req_wdata, 8'h00};
      2'b10:   frame = {1'b1, req_addr[9:3], req_addr[2:0], 5'b00000, 8'h00};
      default: frame = {1'b1, req_addr[9:3], req_addr[2:0], 1'b1, 4'b0000, req_wdata};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div      <= '0;
      sh       <= '0;
      bit_no   <= '0;
      last_bit <= '0;
      rx       <= '0;
      rd_q     <= 1'b0;
      gap2     <= 1'b0;
      sck_q    <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        div <= '0;
        if (req_valid) begin
          sh       <= frame;
          last_bit <= req_long ? 5'd23 : 5'd15;
          bit_no   <= '0;
          rd_q     <= ~req_write;
          st       <= S_LOW;
        end
      end else begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          case (st)
            S_LOW: begin
              sck_q <= 1'b1;
              rx    <= {rx[6:0], miso};
              st    <= S_HIGH;
            end
            S_HIGH: begin
              sck_q <= 1'b0;
              if (bit_no == last_bit) begin
                st <= S_TAIL;
              end else begin
                bit_no <= bit_no + 1'b1;
                sh     <= {sh[FW-2:0], 1'b0};
                st     <= S_LOW;
              end
            end
            S_TAIL: begin
              gap2 <= 1'b0;
              st   <= S_GAP;
            end
            default: begin
              if (gap2) begin
                st   <= S_IDLE;
                done <= 1'b1;
                if (rd_q) rd_data <= rx;
              end else begin
                gap2 <= 1'b1;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

module spi_reg_master_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic irq_en_out
);
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_en_out);
  // R6
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R6
  cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  // R5
  mosi_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sck);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);
endmodule

bind spi_reg_master spi_reg_master_chk u_chk (.*);

// File: tb/spi_reg_master_bench.sv
module spi_reg_master_bench;
  localparam int H = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_long = 0, req_write = 0, irq_en_in = 1;
  logic [9:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic irq_en_out, busy, done, sck, cs_n, mosi, miso;
  logic [7:0] rd_data;

  int tests = 0, fails = 0;
  int total = 0, start = 0, frames = 0, hdr = 8, cyc = 0, last_rise = 0;
  int per_bad = 0, run = 0, min_gap = 1000000;
  logic [63:0] cap = 0;
  logic [7:0] resp = 0;

  always #2.5 clk = ~clk;

  spi_reg_master #(.SCK_HALF(H)) u_spi_reg_master (.*);

  assign miso = ((total - start) >= hdr && (total - start) < hdr + 8) ?
                resp[7 - ((total - start) - hdr)] : 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (cs_n) run <= run + 1;
      else begin
        if (run != 0 && frames > 1 && run < min_gap) min_gap = run;
        run <= 0;
      end
    end
  end

  always @(negedge cs_n) begin
    start  = total;
    frames = frames + 1;
  end

  always @(posedge sck) begin
    if (total != start && (cyc - last_rise) != 2 * H) per_bad = per_bad + 1;
    last_rise = cyc;
    cap   <= {cap[62:0], mosi};
    total <= total + 1;
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic xfer(input bit lg, input bit wr, input int addr, input int wd, input bit poke);
    logic [23:0] ef;
    logic [7:0] prev;
    int nb, f0, b0, b1;
    prev = rd_data;
    if (lg) begin
      b0 = 8'h80 | (addr >> 3);
      b1 = ((addr & 7) << 5) | (wr << 4);
      ef = {b0[7:0], b1[7:0], wr ? wd[7:0] : 8'h00};
      nb = 24;
    end else begin
      b0 = ((addr & 63) << 1) | wr;
      ef = {8'h00, b0[7:0], wr ? wd[7:0] : 8'h00};
      nb = 16;
    end
    hdr  = nb - 8;
    resp = 8'h5A ^ addr[7:0] ^ {7'b0, lg};
    f0   = frames;
    @(negedge clk);
    req_valid = 1; req_long = lg; req_write = wr;
    req_addr = addr[9:0]; req_wdata = wd[7:0];
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b1, "R8 busy after accept", busy, 1);
    for (int i = 0; !done && i < 400; i++) begin
      if (poke && i == 10) begin
        req_valid = 1; req_addr = ~addr[9:0]; req_write = ~wr;
      end else req_valid = 0;
      if (i == 5) chk(irq_en_out === 1'b0, "R7 masked while busy", irq_en_out, 0);
      @(negedge clk);
    end
    req_valid = 0;
    chk(done === 1'b1 && busy === 1'b0, "R8 done with busy low", {done, busy}, 2'b10);
    chk(frames == f0 + 1, "R8 one frame per request", frames - f0, 1);
    chk(total - start == nb, "R6 bit count", total - start, nb);
    if (lg && wr)       chk(cap[23:0] == ef, "R3 long write frame", cap[23:0], ef);
    else if (lg)        chk(cap[23:0] == ef, "R4 long read frame", cap[23:0], ef);
    else if (wr)        chk(cap[15:0] == ef[15:0], "R1 short write frame", cap[15:0], ef[15:0]);
    else                chk(cap[15:0] == ef[15:0], "R2 short read frame", cap[15:0], ef[15:0]);
    if (wr) chk(rd_data == prev, "R10 write keeps rd_data", rd_data, prev);
    else    chk(rd_data == resp, lg ? "R4 read data" : "R2 read data", rd_data, resp);
    chk(irq_en_out === irq_en_in, "R7 restored", irq_en_out, irq_en_in);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1 && sck === 0 && busy === 0 && done === 0, "R6 reset idle", {cs_n, sck, busy, done}, 4'b1000);
    chk(rd_data === 8'h00, "R10 reset rd_data", rd_data, 0);
    rst_n = 1;
    @(negedge clk);
    irq_en_in = 0;
    #1;
    chk(irq_en_out === 1'b0, "R7 idle follows input", irq_en_out, 0);
    irq_en_in = 1;
    #1;
    chk(irq_en_out === 1'b1, "R7 idle follows input", irq_en_out, 1);
    for (int a = 0; a < 64; a++) begin
      xfer(0, 0, a, 0, a[0]);
      xfer(0, 1, a, (a * 37) & 255, a[1]);
    end
    for (int a = 0; a < 1024; a += 31) begin
      xfer(1, 1, a, (a * 11 + 3) & 255, a[0]);
      xfer(1, 0, a, 0, a[1]);
    end
    xfer(1, 0, 1023, 0, 0);
    xfer(1, 1, 1023, 8'hA5, 1);
    chk(min_gap >= 2 * H, "R9 cs high gap", min_gap, 2 * H);
    chk(per_bad == 0, "R11 sck period", per_bad, 0);
    chk(sck === 0 && cs_n === 1, "R5 sck idles low", sck, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule